// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the byte-wide register side of a two-channel asynchronous serial controller. A host reaches sixteen write registers and sixteen read registers per channel through just two byte locations per channel: a control location and a data location. Register selection is indirect. A control write while the channel's pointer is zero loads the pointer. The next control access then touches the selected register, and the pointer drops back to zero. The bit-serial shifters are not part of the block. Received bytes arrive on a per-channel valid/byte input, and a break indication arrives on a per-channel pulse.

The block tracks receive and transmit pending flags and in-service flags for each channel. Receive service always outranks transmit service. From these flags it builds a shared, status-modified interrupt vector and a combined pending-bits register, and it drives a single registered interrupt line. It also decodes each channel's framing and baud settings into registered outputs: a divisor relative to the channel clock, the parity mode, the stop-bit choice and the character width. A software reset command, issued through master register 9, restores one channel or both channels.

Top module: `dual_serial_regif`

## Requirements
- R1: Address bit ADDR_SHIFT selects control (0) or data (1), and address bit ADDR_SHIFT+1 selects channel B (0) or channel A (1). Address bits below ADDR_SHIFT are ignored.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. When the command field (bits 5:3) is 001, 8 is added to the pointer. Command 101 clears the channel's transmit pending and transmit in-service flags. Command 111 resets the highest in-service flag.
- R3: A control write to a non-zero pointer stores the byte in that write register. That write, or any control read, returns the pointer to 0.
- R4: An accepted receive byte sets receive pending and receive in-service. A data write sets transmit pending; it sets transmit in-service only if receive is not in service. A data read, or command 111 while receive is in service, clears receive in-service and promotes a pending transmit into service.
- R5: Read register 2 of channel B returns the vector, with priority A receive > B receive > A transmit > B transmit > none. The codes are 0x0C, 0x04, 0x08, 0x00, 0x06 when bit 4 of write register 9 is 0, and 0x30, 0x20, 0x10, 0x00, 0x60 when it is 1. Write register 9 is shared by both channels.
- R6: Read register 3 of channel A returns the pending bits: B break 0x01, B transmit 0x02, B receive 0x04, A break 0x08, A transmit 0x10, A receive 0x20. Read register 3 of channel B returns 0.
- R7: One clock after the flags change, the interrupt output is the OR over both channels of three terms: write 1 bit 1 AND transmit pending; write 1 bits 4:3 equal to 01 or 10 AND receive pending; write 15 bit 7 AND break status.
- R8: Writing write register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both channels and clears bit 4 of write register 9. A reset channel reads 0x44 in register 0 and 0x07 in register 1. Its write registers restore to 4=0x04, 11=0x08, 14=0x30, 15=0xF8, and 0 elsewhere.
- R9: The divisor output equals (time constant + 2) times 1, 16, 32 or 64, selected by write 4 bits 7:6 (00, 01, 10, 11). The time constant is write 13 (high byte) concatenated with write 12 (low byte), and both of these read back through read registers 13 and 12.
- R10: The parity output is 00 when write 4 bit 0 is clear, otherwise 10 (even) when bit 1 is set and 01 (odd) when it is clear. The two-stop output is 1 only when write 4 bits 3:2 are 11. The width output is 5, 7, 6 or 8 for write 5 bits 6:5 equal to 00, 01, 10 or 11.
- R11: A byte is accepted only while write 3 bit 0 is set and no byte is held. Read register 0 bit 0 shows a held byte. A data read returns the held byte and clears bit 0 and receive pending.
- R12: A break pulse sets read register 0 bit 7. Only a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered, valid the cycle after the read strobe |
| rx_valid_a | input | 1 | Channel A received byte valid |
| rx_byte_a | input | 8 | Channel A received byte |
| rx_valid_b | input | 1 | Channel B received byte valid |
| rx_byte_b | input | 8 | Channel B received byte |
| brk_a | input | 1 | Channel A break detected pulse |
| brk_b | input | 1 | Channel B break detected pulse |
| irq | output | 1 | Combined interrupt request |
| baud_div_a | output | 23 | Channel A divisor of the channel clock |
| parity_a | output | 2 | Channel A parity: 00 none, 01 odd, 10 even |
| stop_two_a | output | 1 | Channel A two stop bits |
| data_bits_a | output | 4 | Channel A character width |
| baud_div_b | output | 23 | Channel B divisor of the channel clock |
| parity_b | output | 2 | Channel B parity |
| stop_two_b | output | 1 | Channel B two stop bits |
| data_bits_b | output | 4 | Channel B character width |

## Verification
The bench builds the block with ADDR_SHIFT=1 and ADDR_W=4. The select and channel bits therefore sit above a don't-care bit, and reading through the odd alias of a control location shows that the low bit is ignored. The four-bit address still covers both channels, so the vector on channel B and the pending bits on channel A can be observed while the other channel's flags change. The divisor table reaches a time constant of 0xFFFE with the 64x prescaler, which exercises the top bit of the 23-bit divisor.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int TC_W  = 16;
  localparam int DIV_W = TC_W + 7;

  localparam logic [2:0] CMD_HI     = 3'b001;
  localparam logic [2:0] CMD_CLR_TX = 3'b101;
  localparam logic [2:0] CMD_CLR_IS = 3'b111;

  localparam logic [7:0] VEC_LO_NONE = 8'h06;
  localparam logic [7:0] VEC_LO_ARX  = 8'h0C;
  localparam logic [7:0] VEC_LO_BRX  = 8'h04;
  localparam logic [7:0] VEC_LO_ATX  = 8'h08;
  localparam logic [7:0] VEC_HI_NONE = 8'h60;
  localparam logic [7:0] VEC_HI_ARX  = 8'h30;
  localparam logic [7:0] VEC_HI_BRX  = 8'h20;
  localparam logic [7:0] VEC_HI_ATX  = 8'h10;
  localparam logic [7:0] VEC_BTX     = 8'h00;

  localparam logic [7:0] MINTR_INIT = 8'hC0;

  function automatic logic [7:0] wreg_init(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] calc_div(input logic [TC_W-1:0] tc,
                                                input logic [1:0] pre);
    logic [DIV_W-1:0] base;
    base = DIV_W'(tc) + DIV_W'(2);
    case (pre)
      2'b00:   return base;
      2'b01:   return base << 4;
      2'b10:   return base << 5;
      default: return base << 6;
    endcase
  endfunction

  function automatic logic [3:0] calc_width(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b01:   return 4'd7;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/dsr_vector.sv
module dsr_vector
  import dsr_pkg::*;
(
  input  logic [1:0] rx_ius,
  input  logic [1:0] tx_ius,
  input  logic       status_hi,
  output logic [7:0] vec
);
  // index 1 is channel A, index 0 is channel B
  always_comb begin
    if (rx_ius[1])      vec = status_hi ? VEC_HI_ARX  : VEC_LO_ARX;
    else if (rx_ius[0]) vec = status_hi ? VEC_HI_BRX  : VEC_LO_BRX;
    else if (tx_ius[1]) vec = status_hi ? VEC_HI_ATX  : VEC_LO_ATX;
    else if (tx_ius[0]) vec = VEC_BTX;
    else                vec = status_hi ? VEC_HI_NONE : VEC_LO_NONE;
  end
endmodule

// File: rtl/dsr_channel.sv
module dsr_channel
  import dsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             ctrl_wr,
  input  logic             data_wr,
  input  logic             ctrl_rd,
  input  logic             data_rd,
  input  logic [7:0]       wdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             brk_set,
  output logic [3:0]       ptr,
  output logic [7:0]       ctrl_val,
  output logic [7:0]       rx_hold,
  output logic             rx_pend,
  output logic             tx_pend,
  output logic             rx_ius,
  output logic             tx_ius,
  output logic             brk_flag,
  output logic             irq_term,
  output logic             mintr_we,
  output logic [DIV_W-1:0] baud_div,
  output logic [1:0]       parity,
  output logic             stop_two,
  output logic [3:0]       data_bits
);
  localparam int NREG = 16;

  logic [7:0] wr_q [NREG];
  logic       avail;
  logic       n_rxp, n_txp, n_rxi, n_txi, n_av;
  logic       accept, cmd_wr;
  logic [2:0] cmd;

  assign cmd      = wdata[5:3];
  assign cmd_wr   = ctrl_wr && (ptr == 4'd0);
  assign mintr_we = ctrl_wr && (ptr == 4'd9);
  assign accept   = rx_valid && wr_q[3][0] && !avail;

  always_comb begin
    n_rxp = rx_pend;
    n_txp = tx_pend;
    n_rxi = rx_ius;
    n_txi = tx_ius;
    n_av  = avail;
    if (cmd_wr) begin
      if (cmd == CMD_CLR_TX) begin
        n_txp = 1'b0;
        n_txi = 1'b0;
      end else if (cmd == CMD_CLR_IS) begin
        if (rx_ius) begin
          n_rxi = 1'b0;
          if (tx_pend) n_txi = 1'b1;
        end else begin
          n_txi = 1'b0;
        end
      end
    end
    if (data_wr) begin
      n_txp = 1'b1;
      if (!rx_ius) n_txi = 1'b1;
    end
    if (data_rd) begin
      n_av  = 1'b0;
      n_rxp = 1'b0;
      n_rxi = 1'b0;
      if (n_txp) n_txi = 1'b1;
    end
    if (accept) begin
      n_av  = 1'b1;
      n_rxp = 1'b1;
      n_rxi = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ptr      <= '0;
      rx_pend  <= 1'b0;
      tx_pend  <= 1'b0;
      rx_ius   <= 1'b0;
      tx_ius   <= 1'b0;
      avail    <= 1'b0;
      brk_flag <= 1'b0;
      rx_hold  <= '0;
      for (int i = 0; i < NREG; i++) wr_q[i] <= wreg_init(i);
    end else begin
      if (ctrl_wr) begin
        if (ptr == 4'd0) begin
          ptr <= {cmd == CMD_HI, wdata[2:0]};
        end else begin
          if (ptr != 4'd9) wr_q[ptr] <= wdata;
          ptr <= '0;
        end
      end else if (ctrl_rd) begin
        ptr <= '0;
      end
      rx_pend <= n_rxp;
      tx_pend <= n_txp;
      rx_ius  <= n_rxi;
      tx_ius  <= n_txi;
      avail   <= n_av;
      if (accept)  rx_hold  <= rx_byte;
      if (brk_set) brk_flag <= 1'b1;
    end
  end

  // registered line-format decode
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      baud_div  <= DIV_W'(2);
      parity    <= 2'b00;
      stop_two  <= 1'b0;
      data_bits <= 4'd5;
    end else begin
      baud_div  <= calc_div({wr_q[13], wr_q[12]}, wr_q[4][7:6]);
      parity    <= wr_q[4][0] ? (wr_q[4][1] ? 2'b10 : 2'b01) : 2'b00;
      stop_two  <= (wr_q[4][3:2] == 2'b11);
      data_bits <= calc_width(wr_q[5][6:5]);
    end
  end

  always_comb begin
    case (ptr)
      4'd0:    ctrl_val = {brk_flag, 1'b1, 3'b000, 1'b1, 1'b0, avail};
      4'd1:    ctrl_val = 8'h07;
      4'd12:   ctrl_val = wr_q[12];
      4'd13:   ctrl_val = wr_q[13];
      default: ctrl_val = 8'h00;
    endcase
  end

  assign irq_term = (wr_q[1][1] && tx_pend)
                  || (((wr_q[1][4:3] == 2'b01) || (wr_q[1][4:3] == 2'b10)) && rx_pend)
                  || (wr_q[15][7] && brk_flag);

  assert_tx_service_pending_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ius |-> tx_pend);
  assert_rx_service_pending_R4: assert property (@(posedge clk) disable iff (rst)
    rx_ius |-> rx_pend);
  assert_ptr_clear_on_read_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !ctrl_wr) |=> (ptr == 4'd0));
  assert_held_byte_kept_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rx_valid && avail) |=> $stable(rx_hold));
  assert_soft_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!rx_pend && !tx_pend && !brk_flag && ptr == 4'd0));
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
#(
  parameter int ADDR_SHIFT = 0,
  parameter int ADDR_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             rx_valid_a,
  input  logic [7:0]       rx_byte_a,
  input  logic             rx_valid_b,
  input  logic [7:0]       rx_byte_b,
  input  logic             brk_a,
  input  logic             brk_b,
  output logic             irq,
  output logic [DIV_W-1:0] baud_div_a,
  output logic [1:0]       parity_a,
  output logic             stop_two_a,
  output logic [3:0]       data_bits_a,
  output logic [DIV_W-1:0] baud_div_b,
  output logic [1:0]       parity_b,
  output logic             stop_two_b,
  output logic [3:0]       data_bits_b
);
  localparam int SEL_BIT = ADDR_SHIFT;
  localparam int CH_BIT  = ADDR_SHIFT + 1;
  localparam int NCH     = 2;

  logic             is_data, ch_sel, rd_en;
  logic [NCH-1:0]   ctrl_wr, data_wr, ctrl_rd, data_rd, soft_rst, mintr_we;
  logic [NCH-1:0]   rx_valid_v, brk_v, rxp, txp, rxi, txi, brk_f, irq_t;
  logic [7:0]       rx_byte_v [NCH];
  logic [7:0]       ctrl_val [NCH];
  logic [7:0]       hold_v [NCH];
  logic [3:0]       ptr_v [NCH];
  logic [DIV_W-1:0] div_v [NCH];
  logic [1:0]       par_v [NCH];
  logic [NCH-1:0]   stop_v;
  logic [3:0]       bits_v [NCH];
  logic [7:0]       mintr_q, vec, pend_bits;

  assign is_data = bus_addr[SEL_BIT];
  assign ch_sel  = bus_addr[CH_BIT];
  assign rd_en   = bus_rd && !bus_wr;

  // index 0 = channel B, index 1 = channel A
  assign rx_valid_v   = {rx_valid_a, rx_valid_b};
  assign brk_v        = {brk_a, brk_b};
  assign rx_byte_v[0] = rx_byte_b;
  assign rx_byte_v[1] = rx_byte_a;

  // reset field bit 6 targets B, bit 7 targets A
  assign soft_rst = (|mintr_we) ? bus_wdata[7:6] : 2'b00;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ctrl_wr[c] = bus_wr && !is_data && (ch_sel == c[0]);
      assign data_wr[c] = bus_wr &&  is_data && (ch_sel == c[0]);
      assign ctrl_rd[c] = rd_en  && !is_data && (ch_sel == c[0]);
      assign data_rd[c] = rd_en  &&  is_data && (ch_sel == c[0]);

      dsr_channel u_ch (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst[c]),
        .ctrl_wr   (ctrl_wr[c]),
        .data_wr   (data_wr[c]),
        .ctrl_rd   (ctrl_rd[c]),
        .data_rd   (data_rd[c]),
        .wdata     (bus_wdata),
        .rx_valid  (rx_valid_v[c]),
        .rx_byte   (rx_byte_v[c]),
        .brk_set   (brk_v[c]),
        .ptr       (ptr_v[c]),
        .ctrl_val  (ctrl_val[c]),
        .rx_hold   (hold_v[c]),
        .rx_pend   (rxp[c]),
        .tx_pend   (txp[c]),
        .rx_ius    (rxi[c]),
        .tx_ius    (txi[c]),
        .brk_flag  (brk_f[c]),
        .irq_term  (irq_t[c]),
        .mintr_we  (mintr_we[c]),
        .baud_div  (div_v[c]),
        .parity    (par_v[c]),
        .stop_two  (stop_v[c]),
        .data_bits (bits_v[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mintr_q <= MINTR_INIT;
    end else if (|mintr_we) begin
      mintr_q <= (bus_wdata[7:6] == 2'b11) ? MINTR_INIT : bus_wdata;
    end
  end

  dsr_vector u_vec (
    .rx_ius    (rxi),
    .tx_ius    (txi),
    .status_hi (mintr_q[4]),
    .vec       (vec)
  );

  assign pend_bits = {2'b00, rxp[1], txp[1], brk_f[1], rxp[0], txp[0], brk_f[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |irq_t;
      if (rd_en) begin
        if (is_data) begin
          bus_rdata <= hold_v[ch_sel];
        end else begin
          case (ptr_v[ch_sel])
            4'd2:    bus_rdata <= ch_sel ? 8'h00 : vec;
            4'd3:    bus_rdata <= ch_sel ? pend_bits : 8'h00;
            default: bus_rdata <= ctrl_val[ch_sel];
          endcase
        end
      end
    end
  end

  assign baud_div_a  = div_v[1];
  assign parity_a    = par_v[1];
  assign stop_two_a  = stop_v[1];
  assign data_bits_a = bits_v[1];
  assign baud_div_b  = div_v[0];
  assign parity_b    = par_v[0];
  assign stop_two_b  = stop_v[0];
  assign data_bits_b = bits_v[0];

  assert_vec_arx_code_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_data && !ch_sel && ptr_v[0] == 4'd2 && rxi[1])
    |=> (bus_rdata == 8'h0C || bus_rdata == 8'h30));
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (rxp == 2'b00 && txp == 2'b00 && brk_f == 2'b00) |=> !irq);
  assert_single_reset_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mintr_we));
endmodule

// File: tb/dual_serial_regif_tb.sv
`timescale 1ns/1ps
module dual_serial_regif_tb_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic          rx_valid_a = 1'b0, rx_valid_b = 1'b0;
  logic [7:0]    rx_byte_a = '0, rx_byte_b = '0;
  logic          brk_a = 1'b0, brk_b = 1'b0;
  logic          irq;
  logic [22:0]   baud_div_a, baud_div_b;
  logic [1:0]    parity_a, parity_b;
  logic          stop_two_a, stop_two_b;
  logic [3:0]    data_bits_a, data_bits_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_serial_regif #(.ADDR_SHIFT(1), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid_a(rx_valid_a), .rx_byte_a(rx_byte_a),
    .rx_valid_b(rx_valid_b), .rx_byte_b(rx_byte_b),
    .brk_a(brk_a), .brk_b(brk_b), .irq(irq),
    .baud_div_a(baud_div_a), .parity_a(parity_a), .stop_two_a(stop_two_a),
    .data_bits_a(data_bits_a),
    .baud_div_b(baud_div_b), .parity_b(parity_b), .stop_two_b(stop_two_b),
    .data_bits_b(data_bits_b)
  );

  typedef struct packed {
    logic [7:0]  m4;
    logic [7:0]  m5;
    logic [15:0] tc;
    logic [22:0] div;
    logic [1:0]  par;
    logic        stop2;
    logic [3:0]  bits;
  } fmt_t;

  localparam fmt_t FMT_TBL [5] = '{
    '{8'h04, 8'h60, 16'h0000, 23'd2,       2'd0, 1'b0, 4'd8},
    '{8'h47, 8'h20, 16'h000A, 23'd192,     2'd2, 1'b0, 4'd7},
    '{8'h8D, 8'h40, 16'h0100, 23'd8256,    2'd1, 1'b1, 4'd6},
    '{8'hC4, 8'h00, 16'hFFFE, 23'd4194304, 2'd0, 1'b0, 4'd5},
    '{8'h0A, 8'h60, 16'h0005, 23'd7,       2'd0, 1'b0, 4'd8}
  };

  // shift 1: bit 1 selects data, bit 2 selects channel A
  function automatic logic [AW-1:0] adr(input bit ch_a, input bit data);
    return {1'b0, ch_a, data, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bwr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic point(input bit ch_a, input int r);
    if (r >= 8) bwr(adr(ch_a, 0), 8'h08 | 8'(r - 8));
    else if (r != 0) bwr(adr(ch_a, 0), 8'(r));
  endtask

  task automatic set_reg(input bit ch_a, input int r, input logic [7:0] v);
    point(ch_a, r);
    bwr(adr(ch_a, 0), v);
  endtask

  task automatic get_reg(input bit ch_a, input int r, output logic [7:0] v);
    point(ch_a, r);
    brd(adr(ch_a, 0), v);
  endtask

  task automatic rx_push(input bit ch_a, input logic [7:0] b);
    @(negedge clk);
    if (ch_a) begin rx_valid_a = 1'b1; rx_byte_a = b; end
    else      begin rx_valid_b = 1'b1; rx_byte_b = b; end
    @(negedge clk);
    rx_valid_a = 1'b0; rx_valid_b = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(2);

    // reset state
    get_reg(1, 0, v); check("R8 A status after reset", v, 8'h44);
    get_reg(1, 1, v); check("R8 A read1 after reset", v, 8'h07);
    get_reg(0, 2, v); check("R5 vector idle low", v, 8'h06);
    check("R7 irq idle", irq, 1'b0);
    check("R8 reset divisor", baud_div_a, 23'd2);
    check("R10 reset width", data_bits_a, 4'd5);
    check("R10 reset parity", parity_a, 2'd0);

    // format and divisor table on channel A
    foreach (FMT_TBL[k]) begin
      set_reg(1, 4, FMT_TBL[k].m4);
      set_reg(1, 5, FMT_TBL[k].m5);
      set_reg(1, 12, FMT_TBL[k].tc[7:0]);
      set_reg(1, 13, FMT_TBL[k].tc[15:8]);
      idle(1);
      check("R9 divisor", baud_div_a, FMT_TBL[k].div);
      check("R10 parity", parity_a, FMT_TBL[k].par);
      check("R10 stop", stop_two_a, FMT_TBL[k].stop2);
      check("R10 width", data_bits_a, FMT_TBL[k].bits);
    end
    check("R9 channel B untouched", baud_div_b, 23'd2);

    // pointer behaviour
    set_reg(1, 12, 8'h34);
    brd(adr(1, 0), v); check("R3 pointer back to 0 after write", v, 8'h44);
    get_reg(1, 12, v); check("R2 pointer plus 8 readback", v, 8'h34);
    brd(adr(1, 0), v); check("R3 pointer back to 0 after read", v, 8'h44);
    point(1, 12);
    brd(adr(1, 0) | 4'd1, v); check("R1 low address bit ignored", v, 8'h34);
    idle(1);
    check("R9 divisor from readback tc", baud_div_a, 23'd54);
    get_reg(1, 13, v); check("R9 high byte readback", v, 8'h00);

    // receive on A
    set_reg(1, 3, 8'h01);
    set_reg(1, 1, 8'h10);
    rx_push(1, 8'h5A);
    idle(1);
    check("R7 irq on rx", irq, 1'b1);
    get_reg(1, 0, v); check("R11 status byte held", v, 8'h45);
    get_reg(0, 2, v); check("R5 vector A rx", v, 8'h0C);
    get_reg(1, 3, v); check("R6 pending A rx", v, 8'h20);
    get_reg(0, 3, v); check("R6 channel B read3 zero", v, 8'h00);
    rx_push(1, 8'h77);
    brd(adr(1, 1), v); check("R11 second byte dropped", v, 8'h5A);
    get_reg(1, 0, v); check("R11 status cleared by read", v, 8'h44);
    idle(1);
    check("R7 irq cleared", irq, 1'b0);
    get_reg(0, 2, v); check("R5 vector none", v, 8'h06);

    // receive outranks transmit on B
    set_reg(0, 3, 8'h01);
    set_reg(0, 1, 8'h12);
    rx_push(0, 8'hC3);
    bwr(adr(0, 1), 8'h33);
    get_reg(0, 2, v); check("R4 tx held off by rx service", v, 8'h04);
    get_reg(1, 3, v); check("R6 pending B rx and tx", v, 8'h06);
    brd(adr(0, 1), v); check("R11 B data", v, 8'hC3);
    get_reg(0, 2, v); check("R4 tx promoted after read", v, 8'h00);
    idle(1);
    check("R7 irq tx pending", irq, 1'b1);
    bwr(adr(0, 0), 8'h28);
    get_reg(0, 2, v); check("R2 clear tx command", v, 8'h06);
    idle(1);
    check("R7 irq after tx clear", irq, 1'b0);

    // in-service reset promotes tx on A
    rx_push(1, 8'h11);
    bwr(adr(1, 1), 8'h22);
    get_reg(0, 2, v); check("R4 A rx in service", v, 8'h0C);
    bwr(adr(1, 0), 8'h38);
    get_reg(0, 2, v); check("R4 reset service promotes tx", v, 8'h08);
    get_reg(1, 3, v); check("R6 pending A rx and tx", v, 8'h30);
    idle(1);
    check("R7 irq rx still pending", irq, 1'b1);
    brd(adr(1, 1), v);
    bwr(adr(1, 0), 8'h28);
    get_reg(0, 2, v); check("R4 all cleared", v, 8'h06);

    // status-high vectors
    set_reg(0, 9, 8'h10);
    get_reg(0, 2, v); check("R5 vector none high", v, 8'h60);
    rx_push(0, 8'h44);
    get_reg(0, 2, v); check("R5 vector B rx high", v, 8'h20);
    brd(adr(0, 1), v);
    rx_push(1, 8'h66);
    get_reg(0, 2, v); check("R5 vector A rx high", v, 8'h30);
    brd(adr(1, 1), v);
    bwr(adr(1, 1), 8'h55);
    get_reg(0, 2, v); check("R5 vector A tx high", v, 8'h10);
    bwr(adr(1, 0), 8'h28);

    // break on B
    @(negedge clk); brk_b = 1'b1;
    @(negedge clk); brk_b = 1'b0;
    get_reg(0, 0, v); check("R12 break status", v, 8'hC4);
    idle(1);
    check("R7 irq on break", irq, 1'b1);
    idle(3);
    get_reg(0, 0, v); check("R12 break sticky", v, 8'hC4);

    // software resets
    set_reg(0, 9, 8'h40);
    get_reg(0, 0, v); check("R8 B reset status", v, 8'h44);
    idle(1);
    check("R8 irq after B reset", irq, 1'b0);
    get_reg(1, 12, v); check("R8 A kept on B reset", v, 8'h34);
    get_reg(0, 2, v); check("R5 status low after write", v, 8'h06);
    rx_push(0, 8'h99);
    get_reg(0, 0, v); check("R11 rx disabled ignored", v, 8'h44);
    set_reg(1, 9, 8'h80);
    get_reg(1, 12, v); check("R8 A reset clears tc", v, 8'h00);
    idle(1);
    check("R8 A reset divisor", baud_div_a, 23'd2);
    check("R8 A reset width", data_bits_a, 4'd5);
    set_reg(0, 9, 8'h10);
    get_reg(0, 2, v); check("R5 high before full reset", v, 8'h60);
    set_reg(1, 9, 8'hC0);
    get_reg(0, 2, v); check("R8 full reset clears status-high", v, 8'h06);
    get_reg(0, 1, v); check("R8 B read1 after full reset", v, 8'h07);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule